// File: doc/BRIEF.md
# Serial Control Register Port

This block is the slave side of a three-wire serial control link (chip select, serial clock, data in) plus a separate data-out line. A host uses it to load and read back a small bank of 8-bit configuration registers and to switch the device between powered-up and powered-down. Every transfer is a whole byte, sent MSB first while the active-low select is held low. Data-in bits are taken on rising serial-clock edges. Read-back bits change on falling edges.

The first byte of a transaction is an instruction. If bit 7 is 0, the byte is a one-byte power command. If bit 7 is 1, the byte opens a register access:
- bit 6 selects read (1) or write (0);
- bits 5:3 carry the register address.

Bit 0 is the power bit in every instruction. A write takes its data from the next eight rising edges, whether or not select goes high between the two bytes. A read returns the addressed register during the next select-low window.

The serial inputs are resynchronised into the system clock domain, and edges are found there. The system clock must run well above the serial clock, at least 8 system clocks per serial half period. `sdo` is meant to feed a pad buffer that `sdoOe` controls. `sdoOe` falls at once, through a combinational path, when select rises, so several devices can share one return line.

Top module: `serctl_port`

## Requirements
- R1: After reset every configuration register reads 0x00, `powerDown` is 1 and `sdoOe` is 0.
- R2: Serial data is taken MSB first on rising `sclk` edges while `csN` is low. An instruction byte with bit 7 = 0 is a power-only command. With bit 7 = 1 it is a register access: bit 6 = 1 means read, bit 6 = 0 means write, and bits 5:3 give the address.
- R3: Bit 0 of every completed instruction byte, including access instructions, sets `powerDown`: 0 powers up and 1 powers down.
- R4: After a write instruction, the next complete byte is stored in the addressed register. This holds when the data byte is in the same select window and when it is in a later one. All other registers are left unchanged.
- R5: After a read instruction, the next select-low window drives the addressed register on `sdo`, MSB first. The first bit is valid once select is low, and each following bit appears after a falling `sclk` edge. `sdoOe` is 1 while the bits are driven.
- R6: `sdoOe` is 0 whenever `csN` is high, and it drops at once when select rises during a read window.
- R7: In a read window, `sdoOe` returns to 0 after the 8th falling `sclk` edge, while `csN` is still low.
- R8: If `csN` rises after 1 to 7 bits, the partial byte is discarded. No register and no power state changes, and a write waiting for its data byte is cancelled.
- R9: Data on `sdi` during a read window is not decoded and changes neither registers nor `powerDown`.
- R10: A power-only command changes no configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial read-back data |
| sdoOe | output | 1 | Output enable for the `sdo` pad buffer |
| powerDown | output | 1 | Power state: 1 = powered down |
| cfgRegs | output | NREG*8 | Register bank, register i in bits [8i+7:8i] |

## Verification
The bench cuts a transfer off at each stage:
- mid-instruction;
- mid-data byte after a write instruction;
- mid-read window.

A design that kept stale bit counts would misalign the next instruction. A design that kept a pending write would store the following power command as data, and a design that held the output enable after select rises would fight other devices on the shared line. Writes are sent both within one select window and split across two, so a port that insisted on either form loses data. Ones are sent on `sdi` during a read window, so a port that still decoded input there would corrupt registers. Registers 0 and 7 are written with 0x01 and 0xFF and read back, which exposes address or bit-order slips. Power bits arriving in access instructions catch a port that only honours the power-only form.

// File: rtl/serctl_pkg.sv
package serctl_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ACC_BIT  = 7;  // 1 = register access
  localparam int unsigned RD_BIT   = 6;  // 1 = read, 0 = write
  localparam int unsigned ADDR_MSB = 5;  // address field top bit
  localparam int unsigned PWR_BIT  = 0;  // 1 = power down

  typedef enum logic [1:0] {
    ST_CMD    = 2'd0,  // collecting an instruction byte
    ST_WDATA  = 2'd1,  // collecting write data
    ST_RWAIT  = 2'd2,  // read pending, waiting for next select window
    ST_RSHIFT = 2'd3   // driving read-back data
  } scpState_t;

  typedef struct packed {
    logic shiftIn;   // take one input bit
    logic cmdDone;   // instruction byte complete
    logic wrCommit;  // write data byte complete
    logic loadTx;    // load read-back shifter
    logic shiftTx;   // advance read-back shifter
  } scpStrobe_t;

endpackage

// File: rtl/serctl_ctrl.sv
module serctl_ctrl
  import serctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       sdi,
  input  logic       instrAcc,
  input  logic       instrRd,
  output scpStrobe_t stb,
  output logic       sdiBit,
  output logic       outEn
);

  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES:0]   sclkPipe;
  logic [SYNC_STAGES:0]   csPipe;
  logic [SYNC_STAGES-1:0] sdiPipe;
  scpState_t              state;
  logic [CNT_W-1:0]       bitCnt;

  logic csS, csFall, csRise, sclkRise, sclkFall, lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      sdiPipe  <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], sclk};
      csPipe   <= {csPipe[SYNC_STAGES-1:0], csN};
      sdiPipe  <= {sdiPipe[SYNC_STAGES-2:0], sdi};
    end
  end

  always_comb begin
    csS      = csPipe[SYNC_STAGES-1];
    csFall   = !csS && csPipe[SYNC_STAGES];
    csRise   = csS && !csPipe[SYNC_STAGES];
    sclkRise = sclkPipe[SYNC_STAGES-1] && !sclkPipe[SYNC_STAGES] && !csS;
    sclkFall = !sclkPipe[SYNC_STAGES-1] && sclkPipe[SYNC_STAGES] && !csS;
    sdiBit   = sdiPipe[SYNC_STAGES-1];
    lastBit  = (bitCnt == LAST_CNT);
  end

  always_comb begin
    stb = '0;
    unique case (state)
      ST_CMD, ST_WDATA: begin
        if (sclkRise) begin
          stb.shiftIn = 1'b1;
          if (lastBit) begin
            if (state == ST_CMD) stb.cmdDone = 1'b1;
            else                 stb.wrCommit = 1'b1;
          end
        end
      end
      ST_RWAIT:  if (csFall) stb.loadTx = 1'b1;
      ST_RSHIFT: if (sclkFall && !lastBit) stb.shiftTx = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_CMD;
      bitCnt <= '0;
      outEn  <= 1'b0;
    end else if (csRise) begin
      bitCnt <= '0;
      outEn  <= 1'b0;
      if (state == ST_RSHIFT || bitCnt != '0) state <= ST_CMD;
    end else begin
      unique case (state)
        ST_CMD: if (sclkRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (lastBit)
            state <= instrAcc ? (instrRd ? ST_RWAIT : ST_WDATA) : ST_CMD;
        end
        ST_WDATA: if (sclkRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (lastBit) state <= ST_CMD;
        end
        ST_RWAIT: if (csFall) begin
          state  <= ST_RSHIFT;
          outEn  <= 1'b1;
          bitCnt <= '0;
        end
        ST_RSHIFT: if (sclkFall) begin
          bitCnt <= bitCnt + 1'b1;
          if (lastBit) begin
            outEn <= 1'b0;
            state <= ST_CMD;
          end
        end
        default: state <= ST_CMD;
      endcase
    end
  end

  // R7: output enable only ever accompanies an active read window
  p_oe_in_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    outEn |-> state == ST_RSHIFT);

  // R2: at most one byte-level action per cycle
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cmdDone, stb.wrCommit, stb.loadTx, stb.shiftTx}));

  // R8: a partial byte cut off by select returns to instruction decode
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && bitCnt != '0 && state != ST_RSHIFT) |=> state == ST_CMD);

  // R9: no input is shifted while a read is pending or active
  p_no_rx_in_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RWAIT || state == ST_RSHIFT) |-> !stb.shiftIn);

endmodule

// File: rtl/serctl_datapath.sv
module serctl_datapath
  import serctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  scpStrobe_t                   stb,
  input  logic                         sdiBit,
  output logic                         instrAcc,
  output logic                         instrRd,
  output logic                         txBit,
  output logic                         powerDown,
  output logic [(1<<ADDR_W)*BYTE_W-1:0] regsFlat
);

  localparam int unsigned NREG = 1 << ADDR_W;

  logic [BYTE_W-1:0]            rxShift;
  logic [BYTE_W-1:0]            rxPeek;
  logic [BYTE_W-1:0]            txShift;
  logic [ADDR_W-1:0]            addrQ;
  logic [NREG-1:0][BYTE_W-1:0]  regFile;

  assign rxPeek   = {rxShift[BYTE_W-2:0], sdiBit};
  assign instrAcc = rxPeek[ACC_BIT];
  assign instrRd  = rxPeek[RD_BIT];
  assign txBit    = txShift[BYTE_W-1];
  assign regsFlat = regFile;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '0;
      addrQ     <= '0;
      powerDown <= 1'b1;
    end else begin
      if (stb.shiftIn) rxShift <= rxPeek;
      if (stb.cmdDone) begin
        powerDown <= rxPeek[PWR_BIT];
        addrQ     <= rxPeek[ADDR_MSB -: ADDR_W];
      end
      if (stb.loadTx)       txShift <= regFile[addrQ];
      else if (stb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                           regFile[gi] <= '0;
      else if (stb.wrCommit && addrQ == ADDR_W'(gi))       regFile[gi] <= rxPeek;
    end
  end

  // R4: the bank only moves when a write data byte completes
  p_regs_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrCommit |=> $stable(regFile));

  // R3: power state only moves when an instruction byte completes
  p_pwr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cmdDone |=> $stable(powerDown));

endmodule

// File: rtl/serctl_port.sv
module serctl_port
  import serctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NREG       = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclk,
  input  logic                   csN,
  input  logic                   sdi,
  output logic                   sdo,
  output logic                   sdoOe,
  output logic                   powerDown,
  output logic [NREG*BYTE_W-1:0] cfgRegs
);

  scpStrobe_t stb;
  logic sdiBit, instrAcc, instrRd, outEn;

  serctl_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclk     (sclk),
    .csN      (csN),
    .sdi      (sdi),
    .instrAcc (instrAcc),
    .instrRd  (instrRd),
    .stb      (stb),
    .sdiBit   (sdiBit),
    .outEn    (outEn)
  );

  serctl_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .sdiBit    (sdiBit),
    .instrAcc  (instrAcc),
    .instrRd   (instrRd),
    .txBit     (sdo),
    .powerDown (powerDown),
    .regsFlat  (cfgRegs)
  );

  // R6: select high releases the line without waiting for the sync chain
  assign sdoOe = outEn & ~csN;

endmodule

// File: tb/tb_serctl_port.sv
module tb_serctl_port;

  localparam int HALF = 8;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic sdi = 1'b0;
  logic sdo, sdoOe, powerDown;
  logic [NREG*8-1:0] cfgRegs;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  logic [7:0] expRegs [NREG];
  logic       expPd;
  logic [7:0] expQ [$];
  event       rdBitEv;

  always #5 clk = ~clk;

  serctl_port dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .powerDown(powerDown), .cfgRegs(cfgRegs)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkState(input string req);
    logic [NREG*8-1:0] flat;
    for (int i = 0; i < NREG; i++) flat[i*8 +: 8] = expRegs[i];
    check(cfgRegs === flat, {req, " regs"}, cfgRegs, flat);
    check(powerDown === expPd, {req, " powerDown"}, powerDown, expPd);
  endtask

  task automatic csLo();
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic csHi();
    waitClk(HALF);
    csN = 1'b1;
    waitClk(HALF);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdi = b[i];
      sclk = 1'b0;
      waitClk(HALF);
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
    waitClk(HALF);
  endtask

  task automatic sendByteWin(input logic [7:0] b);
    csLo();
    sendBits(b, 8);
    csHi();
  endtask

  // Read window: expected byte goes to the scoreboard, the monitor compares
  task automatic readWin(input logic [7:0] exp, input logic sdiVal);
    expQ.push_back(exp);
    csLo();
    ->rdBitEv;
    for (int i = 0; i < 8; i++) begin
      sdi = sdiVal;
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
      waitClk(HALF);
      if (i < 7) ->rdBitEv;
    end
    check(sdoOe === 1'b0, "R7 release after 8th falling edge", sdoOe, 0);
    csHi();
    check(sdoOe === 1'b0, "R6 oe low with select high", sdoOe, 0);
  endtask

  // Monitor: collects read-back bits and pops the scoreboard
  initial begin
    logic [7:0] rxSh;
    int nb;
    rxSh = '0;
    nb = 0;
    forever begin
      @(rdBitEv);
      check(sdoOe === 1'b1, "R5 oe during read", sdoOe, 1);
      rxSh = {rxSh[6:0], sdo};
      nb++;
      if (nb == 8) begin
        logic [7:0] e;
        nb = 0;
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected read data", rxSh, 0);
        end else begin
          e = expQ.pop_front();
          check(rxSh === e, "R5 read-back byte", rxSh, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) expRegs[i] = 8'h00;
    expPd = 1'b1;
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);

    // R1 reset state
    checkState("R1 reset");
    check(sdoOe === 1'b0, "R1 oe at reset", sdoOe, 0);

    // R3 R10 power-only power up
    sendByteWin(8'h00);
    expPd = 1'b0;
    checkState("R10 power-only up");

    // R4 R2 write reg5 in one window (instr 0xA8)
    csLo(); sendBits(8'hA8, 8); sendBits(8'hA5, 8); csHi();
    expRegs[5] = 8'hA5;
    checkState("R4 write same window");

    // R4 R3 write reg2 split across windows, P=1 in access instr (0x91)
    sendByteWin(8'h91);
    expPd = 1'b1;
    checkState("R3 power bit in access instr");
    sendByteWin(8'h3C);
    expRegs[2] = 8'h3C;
    checkState("R4 write split windows");

    // R10 power-only with don't-care bits set (0x46): up
    sendByteWin(8'h46);
    expPd = 1'b0;
    checkState("R10 power-only ignores other bits");

    // R5 R7 read reg5 (0xE8)
    sendByteWin(8'hE8);
    readWin(8'hA5, 1'b0);
    checkState("R5 read leaves state");

    // R9 read reg2 (0xD0) with ones on sdi
    sendByteWin(8'hD0);
    readWin(8'h3C, 1'b1);
    checkState("R9 sdi ignored in read window");

    // R8 abort mid-instruction, then clean power-only
    csLo(); sendBits(8'hE8, 5); csHi();
    checkState("R8 partial instruction discarded");
    sendByteWin(8'h01);
    expPd = 1'b1;
    checkState("R8 realigned after abort");

    // R8 abort mid-data: pending write to reg1 cancelled
    sendByteWin(8'h88);
    expPd = 1'b0;
    csLo(); sendBits(8'hFF, 3); csHi();
    checkState("R8 partial data discarded");
    sendByteWin(8'h01);
    expPd = 1'b1;
    checkState("R8 pending write cancelled");
    sendByteWin(8'hC9);
    readWin(8'h00, 1'b0);

    // R6 select rising mid-read drops oe immediately
    sendByteWin(8'hE8);
    expPd = 1'b0;
    csLo();
    check(sdoOe === 1'b1, "R6 oe up at read start", sdoOe, 1);
    sendBits(8'h00, 3);
    csN = 1'b1;
    #1;
    check(sdoOe === 1'b0, "R6 oe drops with select", sdoOe, 0);
    waitClk(HALF);
    checkState("R6 after cut read");

    // R4 R5 boundary registers 7 and 0
    csLo(); sendBits(8'hB8, 8); sendBits(8'hFF, 8); csHi();
    expRegs[7] = 8'hFF;
    csLo(); sendBits(8'h80, 8); sendBits(8'h01, 8); csHi();
    expRegs[0] = 8'h01;
    checkState("R4 boundary writes");
    sendByteWin(8'hF8);
    readWin(8'hFF, 1'b0);
    sendByteWin(8'hC0);
    readWin(8'h01, 1'b0);
    checkState("R2 final state");

    check(expQ.size() == 0, "R5 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule